// File: doc/BRIEF.md
# Horizontal Raster Timing Generator

This block produces the horizontal timing of one raster line for a CRT-style display controller. A character-clock counter steps once for each cycle in which the character enable is high. It runs from zero up to a terminal count and then wraps. Fixed comparisons against programmed values derive display-enable, horizontal blank and horizontal sync. A one-cycle line-end strobe marks each wrap so that the vertical logic can advance its own line counter.

The programmed values sit in a small register bank written through a simple indexed write port. The blank-end and sync-end values are not compared against the full count. Each closes its window on the first later count whose low bits match, so a window can end on a short value and still span the wrap of the line. Two-bit skew fields hold back display-enable and sync by up to three character clocks. A lock input write-protects the whole timing bank except one bit of the overflow byte.

Top module: `hrt_timing`

## Requirements
- R1: The count changes only in cycles with `chr_en` high. It steps 0, 1, … up to (total register + 4) and then returns to 0, so a line lasts total + 5 character clocks. While `chr_en` is low, every timing output keeps its value.
- R2: `line_end` is high for exactly one clock cycle. That cycle follows the character tick that wraps the count to 0.
- R3: Before skew, display-enable is high while the count is at most the display-end register, which gives display-end + 1 active clocks starting at count 0. Bits 6:5 of the blank-end register (index 3) delay `disp_en` by that many character ticks (0 to 3).
- R4: `hblank` goes high when the count equals the blank-start register. It falls at the first later count whose low 6 bits equal a 6-bit stop value. Bits 4:0 of that value come from blank-end bits 4:0, and bit 5 comes from sync-end bit 7.
- R5: The sync window opens when the count equals the sync-start register. It closes at the first later count whose low 5 bits equal sync-end bits 4:0.
- R6: Bits 6:5 of the sync-end register delay `hsync` by 0 to 3 character ticks. `hsync` is active high when parameter `SYNC_ACT_HIGH` is 1, its default.
- R7: A write with `wr_en` high stores `wr_data` at index `wr_idx` and takes effect from the next cycle. The indices are 0 total, 1 display end, 2 blank start, 3 blank end, 4 sync start, 5 sync end and 7 overflow (shown on `ovf_reg`). Index 6 stores nothing.
- R8: While `wr_lock` is high, writes to indices 0 to 7 are ignored. The one exception is bit 4 of the overflow byte (the line-compare bit 8), which is always written.
- R9: Reset (synchronous, `rst_n` low) clears every register, the count, the skew pipes, blank, sync and `line_end`. Right after reset `disp_en` is high, because count 0 does not exceed a display end of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chr_en | input | 1 | Character clock enable; one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_lock | input | 1 | Write protect for indices 0 to 7 |
| wr_idx | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| disp_en | output | 1 | Display enable, after skew |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync, after skew and polarity |
| line_end | output | 1 | One-cycle strobe after each line wrap |
| ovf_reg | output | 8 | Stored overflow byte |

## Verification
On every cycle, the assertions check the following:
- the count holds without an enable and wraps at the terminal count;
- the line-end strobe is a single cycle that coincides with count 0;
- blank and sync windows open only at their start count and close only where the low-bit match holds;
- a locked write leaves the total register unchanged.

Only the bench's scenarios can show the following:
- the absolute placement and length of each window across a whole line, including a blank window that straddles the wrap;
- the effect of the sync-end bit 7 on the blank stop;
- the skew delays;
- the overflow bit that bypasses the lock, seen at the port.

// File: rtl/hrt_pkg.sv
// Shared definitions for the horizontal raster timing generator.
// Assumes 8-bit timing registers and an 8-entry protected index space.
package hrt_pkg;
    localparam int RW     = 8;           // register width
    localparam int CW     = RW + 1;      // counter width: total + 4 may exceed 8 bits
    localparam int IW     = 3;           // register index width
    localparam int BMW    = 6;           // blank stop match width
    localparam int SMW    = 5;           // sync stop match width
    localparam int SKW    = 2;           // skew field width
    localparam int MAXSK  = (1 << SKW) - 1;
    localparam int LC_BIT = 4;           // overflow bit that ignores the lock
    localparam int TERM_ADD = 4;         // count runs to total + TERM_ADD

    typedef enum logic [IW-1:0] {
        IX_TOTAL  = 3'd0,
        IX_DEND   = 3'd1,
        IX_BSTART = 3'd2,
        IX_BEND   = 3'd3,
        IX_SSTART = 3'd4,
        IX_SEND   = 3'd5,
        IX_RSVD   = 3'd6,
        IX_OVF    = 3'd7
    } hrt_idx_e;

    typedef struct packed {
        logic [RW-1:0] total;
        logic [RW-1:0] dend;
        logic [RW-1:0] bstart;
        logic [RW-1:0] bend;
        logic [RW-1:0] sstart;
        logic [RW-1:0] send;
        logic [RW-1:0] ovf;
    } hrt_regs_t;
endpackage

// File: rtl/hrt_regs.sv
// Timing register bank with an indexed write port and write lock.
// Assumes writes are single-cycle strobes; a locked write only updates
// the overflow line-compare bit.
module hrt_regs
    import hrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_lock,
    input  logic [IW-1:0] wr_idx,
    input  logic [RW-1:0] wr_data,
    output hrt_regs_t     regs
);
    // Register storage: cleared on reset, written by index when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            if (hrt_idx_e'(wr_idx) == IX_OVF) begin
                if (wr_lock) regs.ovf[LC_BIT] <= wr_data[LC_BIT];
                else         regs.ovf         <= wr_data;
            end else if (!wr_lock) begin
                case (hrt_idx_e'(wr_idx))
                    IX_TOTAL:  regs.total  <= wr_data;
                    IX_DEND:   regs.dend   <= wr_data;
                    IX_BSTART: regs.bstart <= wr_data;
                    IX_BEND:   regs.bend   <= wr_data;
                    IX_SSTART: regs.sstart <= wr_data;
                    IX_SEND:   regs.send   <= wr_data;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hrt_counter.sv
// Character-clock counter with terminal wrap and line-end strobe.
// Assumes tick is a single-cycle enable; terminal = total + TERM_ADD.
module hrt_counter
    import hrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] total,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic [CW-1:0] term,
    output logic          line_end
);
    // Terminal count for the current total register.
    assign term = CW'(total) + CW'(TERM_ADD);

    // Value the counter takes on the next tick.
    always_comb begin
        if (cnt == term) cnt_nxt = '0;
        else             cnt_nxt = cnt + CW'(1);
    end

    // Count register: advances only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt_nxt;
    end

    // Line-end strobe: one cycle after the wrapping tick.
    always_ff @(posedge clk) begin
        if (!rst_n) line_end <= 1'b0;
        else        line_end <= tick && (cnt == term);
    end
endmodule

// File: rtl/hrt_window.sv
// Set/clear timing window: opens on a full-width start match and closes
// on a low-bit match of the next count. Start has priority over stop.
module hrt_window
    import hrt_pkg::*;
#(
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [RW-1:0] start,
    input  logic [MW-1:0] stop,
    output logic          active
);
    // Window state: updated together with the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (tick) begin
            if (cnt_nxt == CW'(start))       active <= 1'b1;
            else if (cnt_nxt[MW-1:0] == stop) active <= 1'b0;
        end
    end
endmodule

// File: rtl/hrt_skew.sv
// Selectable 0..MAXD tick delay for a timing level.
// Assumes the delay select changes only between lines.
module hrt_skew
    import hrt_pkg::*;
#(
    parameter int MAXD = MAXSK
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           raw,
    input  logic [SKW-1:0] sel,
    output logic           dly
);
    logic [MAXD:1] sh;
    logic [MAXD:0] taps;

    for (genvar i = 1; i <= MAXD; i++) begin : g_stage
        // Delay stage i: shifts one position per tick.
        always_ff @(posedge clk) begin
            if (!rst_n)    sh[i] <= 1'b0;
            else if (tick) sh[i] <= (i == 1) ? raw : sh[(i > 1) ? i - 1 : 1];
        end
    end

    // Tap selection: tap 0 is the undelayed level.
    assign taps = {sh, raw};
    assign dly  = taps[sel];
endmodule

// File: rtl/hrt_timing.sv
// Horizontal raster timing generator top. Builds display-enable, blank,
// sync and line-end from a character-clock counter and a register bank.
// Assumes chr_en is synchronous to clk.
module hrt_timing
    import hrt_pkg::*;
#(
    parameter bit SYNC_ACT_HIGH = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_en,
    input  logic          wr_en,
    input  logic          wr_lock,
    input  logic [IW-1:0] wr_idx,
    input  logic [RW-1:0] wr_data,
    output logic          disp_en,
    output logic          hblank,
    output logic          hsync,
    output logic          line_end,
    output logic [RW-1:0] ovf_reg
);
    hrt_regs_t      regs;
    logic [CW-1:0]  cnt, cnt_nxt, term;
    logic [BMW-1:0] bstop;
    logic [SMW-1:0] sstop;
    logic           de_raw, sync_win, sync_dly;

    hrt_regs u_regs (
        .clk, .rst_n, .wr_en, .wr_lock, .wr_idx, .wr_data, .regs
    );

    hrt_counter u_cnt (
        .clk, .rst_n, .tick(chr_en), .total(regs.total),
        .cnt, .cnt_nxt, .term, .line_end
    );

    // Stop values: blank stop takes its top bit from sync-end bit 7.
    assign bstop = {regs.send[RW-1], regs.bend[BMW-2:0]};
    assign sstop = regs.send[SMW-1:0];

    hrt_window #(.MW(BMW)) u_blank (
        .clk, .rst_n, .tick(chr_en), .cnt_nxt,
        .start(regs.bstart), .stop(bstop), .active(hblank)
    );

    hrt_window #(.MW(SMW)) u_sync (
        .clk, .rst_n, .tick(chr_en), .cnt_nxt,
        .start(regs.sstart), .stop(sstop), .active(sync_win)
    );

    // Undelayed display region.
    assign de_raw = (cnt <= CW'(regs.dend));

    hrt_skew u_de_skew (
        .clk, .rst_n, .tick(chr_en), .raw(de_raw),
        .sel(regs.bend[BMW-1 +: SKW]), .dly(disp_en)
    );

    hrt_skew u_sync_skew (
        .clk, .rst_n, .tick(chr_en), .raw(sync_win),
        .sel(regs.send[SMW +: SKW]), .dly(sync_dly)
    );

    // Output polarity of sync.
    assign hsync   = SYNC_ACT_HIGH ? sync_dly : ~sync_dly;
    assign ovf_reg = regs.ovf;
endmodule

// File: rtl/hrt_timing_chk.sv
// Protocol checker for hrt_timing, attached by bind below.
module hrt_timing_chk
    import hrt_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           chr_en,
    input logic           wr_en,
    input logic           wr_lock,
    input logic [CW-1:0]  cnt,
    input logic [CW-1:0]  term,
    input logic           line_end,
    input logic           blank,
    input logic [RW-1:0]  bstart,
    input logic [BMW-1:0] bstop,
    input logic           sync_win,
    input logic [RW-1:0]  sstart,
    input logic [SMW-1:0] sstop,
    input logic [RW-1:0]  total
);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_en |=> $stable(cnt));
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_en && cnt == term) |=> (cnt == '0));
    a_r2_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> (cnt == '0));
    a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);
    a_r4_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> (cnt == CW'(bstart)));
    a_r4_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank) |-> (cnt[BMW-1:0] == bstop));
    a_r5_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_win) |-> (cnt == CW'(sstart)));
    a_r5_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_win) |-> (cnt[SMW-1:0] == sstop));
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock) |=> $stable(total));
endmodule

bind hrt_timing hrt_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chr_en(chr_en), .wr_en(wr_en),
    .wr_lock(wr_lock), .cnt(cnt), .term(term), .line_end(line_end),
    .blank(hblank), .bstart(regs.bstart), .bstop(bstop),
    .sync_win(sync_win), .sstart(regs.sstart), .sstop(sstop),
    .total(regs.total)
);

// File: tb/tb_hrt_timing.sv
module tb_hrt_timing;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_lock = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       disp_en, hblank, hsync, line_end;
    logic [7:0] ovf_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    hrt_timing dut (
        .clk, .rst_n, .chr_en, .wr_en, .wr_lock, .wr_idx, .wr_data,
        .disp_en, .hblank, .hsync, .line_end, .ovf_reg
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; chr_en = 1'b0; wr_en = 1'b0; wr_lock = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic wr(input int idx, input int data);
        @(negedge clk) wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(data);
        @(negedge clk) wr_en = 1'b0;
    endtask

    // One character tick; returns at the falling edge after it.
    task automatic tick();
        @(negedge clk) chr_en = 1'b1;
        @(negedge clk) chr_en = 1'b0;
    endtask

    // Circular window [s, e) over count c; nothing before s in the first line.
    function automatic bit win(int t, int p, int s, int e);
        int c = t % p;
        if (t < p && c < s) return 1'b0;
        if (s < e) return (c >= s && c < e);
        return (c >= s || c < e);
    endfunction

    function automatic bit de_exp(int t, int p, int dend, int sk);
        if (t < sk) return 1'b0;
        return ((t - sk) % p) <= dend;
    endfunction

    function automatic bit sy_exp(int t, int p, int s, int e, int sk);
        if (t < sk) return 1'b0;
        return win(t - sk, p, s, e);
    endfunction

    // Run n ticks and compare every output against the requirement formulas.
    task automatic run_line(int n, int p, int dend, int dsk, int bs, int be,
                            int ss, int se, int ssk);
        for (int t = 1; t <= n; t++) begin
            tick();
            chk(disp_en,  de_exp(t, p, dend, dsk),       "R3 disp_en");
            chk(hblank,   win(t, p, bs, be),             "R4 hblank");
            chk(hsync,    sy_exp(t, p, ss, se, ssk),     "R5/R6 hsync");
            chk(line_end, (t % p) == 0,                  "R1/R2 line_end");
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(disp_en, 1, "R9 disp_en");
        chk(hblank, 0, "R9 hblank");
        chk(hsync, 0, "R9 hsync");
        chk(line_end, 0, "R9 line_end");
        chk(ovf_reg, 8'h00, "R9 ovf_reg");
    endtask

    // R1 R3 R4 R5: period 11, no skew, short windows.
    task automatic t_basic();
        do_reset();
        wr(0, 6); wr(1, 5); wr(2, 7); wr(3, 8'h09); wr(4, 8); wr(5, 8'h0A);
        run_line(22, 11, 5, 0, 7, 9, 8, 10, 0);
    endtask

    // R1: with no enable all outputs hold (count sits at 8).
    task automatic t_hold();
        for (int i = 0; i < 8; i++) tick();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(disp_en, 0, "R1 hold disp_en");
            chk(hblank, 1, "R1 hold hblank");
            chk(hsync, 1, "R1 hold hsync");
            chk(line_end, 0, "R1 hold line_end");
        end
    endtask

    // R8 lock, then R7 unlocked writes (count starts at 8, period 11).
    task automatic t_lock();
        wr_lock = 1'b1;
        wr(0, 20);
        wr(7, 8'hFF);
        chk(ovf_reg, 8'h10, "R8 locked ovf only bit4");
        tick(); tick();
        chk(line_end, 0, "R8 no wrap early");
        tick();
        chk(line_end, 1, "R8 total unchanged, wrap at 11");
        wr_lock = 1'b0;
        wr(7, 8'hFF);
        chk(ovf_reg, 8'hFF, "R7 ovf write");
        wr(6, 8'h55);
        chk(ovf_reg, 8'hFF, "R7 index 6 no effect");
        wr(0, 2);
        for (int i = 1; i <= 7; i++) begin
            tick();
            chk(line_end, i == 7, "R7 new total period 7");
        end
    endtask

    // R4 6-bit stop with bit5 from sync-end bit7, R5 5-bit stop, R3/R6 skews.
    task automatic t_mod_skew();
        do_reset();
        wr(0, 70); wr(1, 63); wr(2, 40); wr(3, 8'h62); wr(4, 20); wr(5, 8'hC3);
        run_line(150, 75, 63, 3, 40, 34, 20, 35, 2);
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_hold();
        t_lock();
        t_mod_skew();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule